// File: doc/BRIEF.md
# Infrared Pulse Modulation Transceiver

This block sits between the serial pins of a UART and an infrared transceiver. On the transmit side it turns every zero bit the UART sends into one short, active-high light pulse. One control byte selects the pulse shape. With a value of 0 the pulse lasts three of the sixteen baud ticks of a bit. With a value from 1 to 254 the pulse lasts exactly that many system clocks. With a value of 255 both directions pass through unchanged.

On the receive side the block samples the infrared input once per system clock. A second control byte sets a run-length filter: a pulse is accepted only after that value plus one consecutive high samples. A value of 0 accepts a single sample. Each accepted pulse drives the UART receive line low for sixteen baud ticks, which restores a full-length zero bit.

Each path has its own enable. Its control byte is captured only while that enable is low, so the UART is expected to program the block while the path is off.

Top module: `ir_pulse_codec`

## Requirements
- R1: After reset `ir_tx` is 0, `uart_rxd` is 1, and both captured control bytes are 0, so the transmit path uses 3/16 pulses and the receive filter is off.
- R2: With transmit control 0, a zero bit gives one pulse of exactly 3 baud-tick periods, and a one bit gives no pulse.
- R3: With transmit control N in 1..254 and N shorter than a bit period, a zero bit gives one pulse of exactly N clock cycles.
- R4: A pulse goes high in the clock cycle after the edge at which `baud_tick` is high and a bit begins. A bit begins when `uart_txd` sampled at a tick is 0 and was 1 at the previous tick. Otherwise a bit begins on every 16th tick after the last bit start.
- R5: A fixed pulse longer than a bit period ends at the next bit start, so the pulse of a zero bit never runs into a following one bit.
- R6: With transmit control 255, `ir_tx` equals `uart_txd` and `uart_rxd` equals `ir_rx` in the same cycle.
- R7: With receive control 0, one clock cycle of `ir_rx` high is accepted, and `uart_rxd` is low in the cycle after that sample.
- R8: With receive control x in 1..255, a pulse is accepted only when `ir_rx` is high for x+1 consecutive clock samples. `uart_rxd` then goes low after the (x+1)th sample. A shorter pulse leaves `uart_rxd` at 1.
- R9: After an accepted pulse, `uart_rxd` stays low until the 16th `baud_tick` after the accepting edge, and returns to 1 at that edge.
- R10: A control byte is captured only while its path enable is low. A change made while the path is enabled has no effect until the path is disabled and enabled again.
- R11: While `tx_en` is low and bypass is not selected, `ir_tx` stays 0. While `rx_en` is low and bypass is not selected, `uart_rxd` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| tx_en | input | 1 | Transmit path enable; control byte captured while low |
| tx_cfg | input | 8 | Transmit control: 0 = 3/16 pulse, 1..254 = clock count, 255 = bypass |
| uart_txd | input | 1 | Serial data from the UART transmitter |
| ir_tx | output | 1 | Active-high drive to the infrared emitter |
| rx_en | input | 1 | Receive path enable; control byte captured while low |
| rx_cfg | input | 8 | Receive filter: 0 = off, x = x+1 equal samples required |
| ir_rx | input | 1 | Active-high output of the infrared detector |
| uart_rxd | output | 1 | Restored serial data to the UART receiver |

## Verification
The start of a transmit pulse is due in the cycle after the tick edge that opens a bit. Its width is due as 3 tick periods or N cycles. A receive acceptance shows on `uart_rxd` exactly x+1 cycles after the first high sample, and the release follows the 16th tick after that. Bypass outputs are combinational and are due in the same cycle as the input. The bench changes inputs one time unit after a falling edge and reads outputs there. Over each 64-cycle bit window it sums the high samples of `ir_tx` and notes the first one. For the receive path it counts the cycles to the first low and the ticks until `uart_rxd` returns high, so every expected value is a cycle or tick count taken from the requirements.

// File: rtl/ir_codec_pkg.sv
`timescale 1ns/1ps
// Shared types for the infrared pulse codec.
// Assumes the transmit control byte has one all-ones code for bypass
// and one all-zeros code for the tick-ratio pulse.
package ir_codec_pkg;

    typedef enum logic [1:0] {
        TXM_RATIO  = 2'd0,
        TXM_FIXED  = 2'd1,
        TXM_BYPASS = 2'd2
    } tx_mode_e;

    // Map a transmit control byte of any width to its pulse mode.
    function automatic tx_mode_e decode_tx_mode(input logic [15:0] code, input int unsigned width);
        logic [15:0] all_ones;
        all_ones = 16'((32'd1 << width) - 32'd1);
        if (code == 16'd0)
            return TXM_RATIO;
        else if (code == all_ones)
            return TXM_BYPASS;
        else
            return TXM_FIXED;
    endfunction

endpackage

// File: rtl/ir_cfg_hold.sv
`timescale 1ns/1ps
// Control byte capture register.
// Follows cfg_in while the path enable is low and holds its value while
// the enable is high. Assumes software writes the byte before enabling.
module ir_cfg_hold #(
    parameter int unsigned CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CFG_W-1:0] cfg_in,
    output logic [CFG_W-1:0] cfg_q
);

    // Capture the byte while disabled, freeze it while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (!enable)
            cfg_q <= cfg_in;
    end

endmodule

// File: rtl/ir_tx_shaper.sv
`timescale 1ns/1ps
// Transmit pulse shaper.
// Tracks the bit grid from the 16x tick and from falling edges of the
// UART data, and emits one active-high pulse per zero bit: either a
// fixed number of ticks or a programmed number of clocks. A pulse is
// cut at the next bit start. Assumes uart_txd only changes on bit
// boundaries of the UART's own tick grid.
module ir_tx_shaper
    import ir_codec_pkg::*;
#(
    parameter int unsigned CFG_W         = 8,
    parameter int unsigned TICKS_PER_BIT = 16,
    parameter int unsigned RATIO_TICKS   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  tx_mode_e         mode,
    input  logic [CFG_W-1:0] width,
    input  logic             baud_tick,
    input  logic             uart_txd,
    output logic             pulse_o
);

    localparam int unsigned PH_W     = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(TICKS_PER_BIT - 1);
    localparam logic [PH_W-1:0] PH_CLEAR = PH_W'(RATIO_TICKS - 1);

    logic [PH_W-1:0]  phase;
    logic             txd_last;
    logic             data_fell;
    logic             bit_start;
    logic [CFG_W-1:0] clk_left;

    assign data_fell = txd_last & ~uart_txd;
    assign bit_start = baud_tick & (data_fell | (phase == PH_LAST));

    // Keep the tick position inside the current bit, resyncing on a falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            phase    <= '0;
            txd_last <= 1'b1;
        end else if (baud_tick) begin
            txd_last <= uart_txd;
            phase    <= bit_start ? '0 : phase + 1'b1;
        end
    end

    // Start, time and end the pulse of each zero bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_o  <= 1'b0;
            clk_left <= '0;
        end else if (!enable || mode == TXM_BYPASS) begin
            pulse_o  <= 1'b0;
            clk_left <= '0;
        end else if (bit_start) begin
            pulse_o  <= ~uart_txd;
            clk_left <= width - 1'b1;
        end else if (pulse_o) begin
            if (mode == TXM_RATIO) begin
                if (baud_tick && phase == PH_CLEAR)
                    pulse_o <= 1'b0;
            end else begin
                if (clk_left == '0)
                    pulse_o <= 1'b0;
                else
                    clk_left <= clk_left - 1'b1;
            end
        end
    end

endmodule

// File: rtl/ir_rx_restore.sv
`timescale 1ns/1ps
// Receive filter and bit restorer.
// Counts consecutive high samples of the detector output, accepts a pulse
// when the count reaches the programmed value plus one, and then holds the
// UART receive line low for a full bit of ticks. Assumes ir_in is already
// synchronous to clk.
module ir_rx_restore #(
    parameter int unsigned CFG_W         = 8,
    parameter int unsigned TICKS_PER_BIT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CFG_W-1:0] need,
    input  logic             baud_tick,
    input  logic             ir_in,
    output logic             rxd_o
);

    localparam int unsigned RUN_W  = CFG_W + 1;
    localparam int unsigned HOLD_W = $clog2(TICKS_PER_BIT + 1);

    logic [RUN_W-1:0]  run_len;
    logic [RUN_W-1:0]  run_goal;
    logic [HOLD_W-1:0] ticks_left;
    logic              accept;

    assign run_goal = {1'b0, need};
    assign accept   = ir_in & (run_len == run_goal);

    // Count consecutive high samples, stopping just past the goal.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            run_len <= '0;
        else if (!ir_in)
            run_len <= '0;
        else if (run_len <= run_goal)
            run_len <= run_len + 1'b1;
    end

    // Hold the restored bit low for one bit period of ticks after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            rxd_o      <= 1'b1;
            ticks_left <= '0;
        end else if (accept) begin
            rxd_o      <= 1'b0;
            ticks_left <= HOLD_W'(TICKS_PER_BIT);
        end else if (!rxd_o && baud_tick) begin
            if (ticks_left == HOLD_W'(1))
                rxd_o <= 1'b1;
            ticks_left <= ticks_left - 1'b1;
        end
    end

endmodule

// File: rtl/ir_pulse_codec.sv
`timescale 1ns/1ps
// Infrared pulse codec top.
// Captures the two control bytes, shapes transmit pulses, filters and
// restores received pulses, and switches both paths to pass-through when
// the transmit byte holds the all-ones code. Assumes baud_tick is a
// one-cycle strobe at TICKS_PER_BIT times the bit rate.
module ir_pulse_codec
    import ir_codec_pkg::*;
#(
    parameter int unsigned CFG_W         = 8,
    parameter int unsigned TICKS_PER_BIT = 16,
    parameter int unsigned RATIO_TICKS   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             tx_en,
    input  logic [CFG_W-1:0] tx_cfg,
    input  logic             uart_txd,
    output logic             ir_tx,
    input  logic             rx_en,
    input  logic [CFG_W-1:0] rx_cfg,
    input  logic             ir_rx,
    output logic             uart_rxd
);

    logic [CFG_W-1:0] tx_cfg_q;
    logic [CFG_W-1:0] rx_cfg_q;
    tx_mode_e         tx_mode;
    logic             bypass;
    logic             shaped_tx;
    logic             restored_rx;

    ir_cfg_hold #(.CFG_W(CFG_W)) u_tx_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (tx_en),
        .cfg_in (tx_cfg),
        .cfg_q  (tx_cfg_q)
    );

    ir_cfg_hold #(.CFG_W(CFG_W)) u_rx_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (rx_en),
        .cfg_in (rx_cfg),
        .cfg_q  (rx_cfg_q)
    );

    // Decode the captured transmit byte into a pulse mode.
    always_comb begin
        tx_mode = decode_tx_mode(16'(tx_cfg_q), CFG_W);
        bypass  = (tx_mode == TXM_BYPASS);
    end

    ir_tx_shaper #(
        .CFG_W         (CFG_W),
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .RATIO_TICKS   (RATIO_TICKS)
    ) u_shaper (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (tx_en),
        .mode      (tx_mode),
        .width     (tx_cfg_q),
        .baud_tick (baud_tick),
        .uart_txd  (uart_txd),
        .pulse_o   (shaped_tx)
    );

    ir_rx_restore #(
        .CFG_W         (CFG_W),
        .TICKS_PER_BIT (TICKS_PER_BIT)
    ) u_restore (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (rx_en),
        .need      (rx_cfg_q),
        .baud_tick (baud_tick),
        .ir_in     (ir_rx),
        .rxd_o     (restored_rx)
    );

    // Select pass-through or coded signals for both pins.
    always_comb begin
        ir_tx    = bypass ? uart_txd : shaped_tx;
        uart_rxd = bypass ? ir_rx    : restored_rx;
    end

endmodule

// File: rtl/ir_pulse_codec_chk.sv
`timescale 1ns/1ps
// Property checker for ir_pulse_codec, attached with bind below.
module ir_pulse_codec_chk #(
    parameter int unsigned CFG_W         = 8,
    parameter int unsigned TICKS_PER_BIT = 16,
    parameter int unsigned RATIO_TICKS   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             baud_tick,
    input logic             tx_en,
    input logic             rx_en,
    input logic             uart_txd,
    input logic             ir_tx,
    input logic             ir_rx,
    input logic             uart_rxd,
    input logic [CFG_W-1:0] tx_cfg_q,
    input logic [CFG_W-1:0] rx_cfg_q
);

    localparam logic [CFG_W-1:0] BYP = {CFG_W{1'b1}};

    logic       byp;
    logic [7:0] hi_ticks;

    assign byp = (tx_cfg_q == BYP);

    // Count ticks seen while a tick-ratio pulse is high.
    always_ff @(posedge clk) begin
        if (!rst_n || !ir_tx)
            hi_ticks <= '0;
        else if (baud_tick && tx_cfg_q == '0 && hi_ticks != 8'hFF)
            hi_ticks <= hi_ticks + 1'b1;
    end

    assert_ratio_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cfg_q == '0 && ir_tx) |-> (hi_ticks < 8'(RATIO_TICKS)));

    assert_pulse_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp && !$past(byp) && $rose(ir_tx)) |-> $past(baud_tick));

    assert_bypass_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byp |-> (ir_tx == uart_txd));

    assert_bypass_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byp |-> (uart_rxd == ir_rx));

    assert_accept_needs_light_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp && !$past(byp) && $fell(uart_rxd)) |-> $past(ir_rx));

    assert_release_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!byp && !$past(byp) && rx_en && $past(rx_en) && $rose(uart_rxd)) |-> $past(baud_tick));

    assert_tx_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en)) |-> $stable(tx_cfg_q));

    assert_rx_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && $past(rx_en)) |-> $stable(rx_cfg_q));

    assert_tx_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !$past(tx_en) && !byp) |-> !ir_tx);

    assert_rx_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !$past(rx_en) && !byp) |-> uart_rxd);

endmodule

bind ir_pulse_codec ir_pulse_codec_chk #(
    .CFG_W         (CFG_W),
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .RATIO_TICKS   (RATIO_TICKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .tx_en     (tx_en),
    .rx_en     (rx_en),
    .uart_txd  (uart_txd),
    .ir_tx     (ir_tx),
    .ir_rx     (ir_rx),
    .uart_rxd  (uart_rxd),
    .tx_cfg_q  (tx_cfg_q),
    .rx_cfg_q  (rx_cfg_q)
);

// File: tb/sim_ir_pulse_codec.sv
`timescale 1ns/1ps
// Bench for ir_pulse_codec: directed corners plus seeded random data.
module sim_ir_pulse_codec;

    localparam int CLK_PERIOD = 10;
    localparam int TDIV       = 4;          // clocks per baud tick
    localparam int TPB        = 16;         // ticks per bit
    localparam int BITC       = TDIV * TPB; // clocks per bit

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       tx_en = 1'b0;
    logic [7:0] tx_cfg = 8'd0;
    logic       uart_txd = 1'b1;
    logic       ir_tx;
    logic       rx_en = 1'b0;
    logic [7:0] rx_cfg = 8'd0;
    logic       ir_rx = 1'b0;
    logic       uart_rxd;

    int checks = 0;
    int fails = 0;
    int tcnt = 0;
    int div = 0;
    bit done = 1'b0;

    ir_pulse_codec u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .tx_en     (tx_en),
        .tx_cfg    (tx_cfg),
        .uart_txd  (uart_txd),
        .ir_tx     (ir_tx),
        .rx_en     (rx_en),
        .rx_cfg    (rx_cfg),
        .ir_rx     (ir_rx),
        .uart_rxd  (uart_rxd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick strobe, changed on falling edges.
    initial begin
        forever begin
            @(negedge clk);
            baud_tick = (div == TDIV - 1);
            div = (div == TDIV - 1) ? 0 : div + 1;
        end
    end

    // Count ticks the design sees.
    initial begin
        forever begin
            @(posedge clk);
            if (baud_tick) tcnt++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    // Expected high cycles of ir_tx within one bit window.
    function automatic int exp_width(input int mode, input bit b);
        if (b) return 0;
        if (mode == 0) return 3 * TDIV;
        return (mode < BITC) ? mode : BITC;
    endfunction

    task automatic wait_tick_slot();
        do begin
            @(negedge clk);
            #1;
        end while (!baud_tick);
    endtask

    task automatic set_tx(input int mode);
        @(negedge clk); #1;
        tx_en = 1'b0;
        tx_cfg = 8'(mode);
        @(negedge clk); @(negedge clk); #1;
        tx_en = 1'b1;
    endtask

    task automatic set_rx(input int x);
        @(negedge clk); #1;
        rx_en = 1'b0;
        rx_cfg = 8'(x);
        @(negedge clk); @(negedge clk); #1;
        rx_en = 1'b1;
    endtask

    // Drive one bit at a tick slot; measure first sample and high count.
    task automatic send_bit(input bit b, input int mode, input bit off, input string req);
        int hi;
        int first;
        int ew;
        hi = 0;
        first = 0;
        uart_txd = b;
        for (int i = 0; i < BITC; i++) begin
            @(posedge clk);
            @(negedge clk); #1;
            if (i == 0) first = int'(ir_tx);
            hi += int'(ir_tx);
        end
        ew = off ? 0 : exp_width(mode, b);
        check(hi == ew && first == ((ew > 0) ? 1 : 0), req, hi * 2 + first, ew * 2 + ((ew > 0) ? 1 : 0));
    endtask

    task automatic send_frame(input logic [7:0] data, input int mode, input bit off, input string req);
        wait_tick_slot();
        send_bit(1'b0, mode, off, req);
        for (int k = 0; k < 8; k++) send_bit(data[k], mode, off, req);
        send_bit(1'b1, mode, off, req);
    endtask

    // Drive a receive pulse of w samples; check acceptance timing and stretch.
    task automatic rx_pulse(input int w, input int x, input bit off, input string req);
        int first_low;
        int rec;
        int span;
        bit rose;
        bit acc;
        first_low = -1;
        rec = 0;
        span = 0;
        rose = 1'b0;
        acc = !off && (w >= x + 1);
        @(negedge clk); #1;
        ir_rx = 1'b1;
        for (int k = 1; k < w + BITC + 40; k++) begin
            @(negedge clk); #1;
            if (k == w) ir_rx = 1'b0;
            if (!uart_rxd && first_low < 0) begin
                first_low = k;
                rec = tcnt;
            end
            if (first_low >= 0 && uart_rxd && !rose) begin
                rose = 1'b1;
                span = tcnt - rec;
            end
            if (k > w && (rose || first_low < 0)) break;
        end
        ir_rx = 1'b0;
        if (acc) begin
            check(first_low == x + 1, req, first_low, x + 1);
            check(rose && span == TPB, "R9", span, TPB);
        end else begin
            check(first_low < 0, req, first_low, -1);
        end
    endtask

    initial begin
        int seed;
        int tx_modes [6];
        int rx_vals [5];
        seed = $urandom(32'h1ce5);
        tx_modes = '{0, 1, 7, 40, 100, 254};
        rx_vals = '{0, 1, 3, 8, 255};

        repeat (3) @(negedge clk);
        #1;
        check(ir_tx == 1'b0, "R1", int'(ir_tx), 0);
        check(uart_rxd == 1'b1, "R1", int'(uart_rxd), 1);
        rst_n = 1'b1;
        tx_cfg = 8'd77;
        rx_cfg = 8'd9;
        @(negedge clk); #1;
        rst_n = 1'b0;
        @(negedge clk); #1;
        rst_n = 1'b1;
        tx_en = 1'b1;
        rx_en = 1'b1;
        // R1: reset left both captured bytes at 0: 3/16 pulses, filter off.
        send_frame(8'h00, 0, 1'b0, "R1");
        rx_pulse(1, 0, 1'b0, "R1");

        // Transmit modes with directed and random data (R2 R3 R4 R5).
        foreach (tx_modes[i]) begin
            set_tx(tx_modes[i]);
            send_frame(8'h5A, tx_modes[i], 1'b0, tx_modes[i] == 0 ? "R2" : (tx_modes[i] < BITC ? "R3" : "R5"));
            send_frame(8'($urandom), tx_modes[i], 1'b0, "R4");
        end

        // Bypass in both directions.
        set_tx(255);
        for (int i = 0; i < 24; i++) begin
            @(negedge clk); #1;
            uart_txd = 1'($urandom);
            ir_rx = 1'($urandom);
            #1;
            check(ir_tx == uart_txd && uart_rxd == ir_rx, "R6",
                  int'({ir_tx, uart_rxd}), int'({uart_txd, ir_rx}));
        end
        ir_rx = 1'b0;
        uart_txd = 1'b1;

        // Receive filter settings (R7 R8), at and around the threshold.
        set_tx(0);
        foreach (rx_vals[i]) begin
            set_rx(rx_vals[i]);
            rx_pulse(rx_vals[i] + 1, rx_vals[i], 1'b0, rx_vals[i] == 0 ? "R7" : "R8");
            if (rx_vals[i] > 0) rx_pulse(rx_vals[i], rx_vals[i], 1'b0, "R8");
            rx_pulse(rx_vals[i] + 1 + int'($urandom % 6), rx_vals[i], 1'b0, "R8");
        end

        // Writes while enabled take no effect until re-enable (R10).
        set_tx(0);
        set_rx(0);
        tx_cfg = 8'd255;
        rx_cfg = 8'd5;
        send_frame(8'h33, 0, 1'b0, "R10");
        rx_pulse(1, 0, 1'b0, "R10");
        set_tx(255);
        @(negedge clk); #1;
        uart_txd = 1'b0;
        #1;
        check(ir_tx == 1'b0, "R10", int'(ir_tx), 0);
        uart_txd = 1'b1;
        set_tx(0);
        set_rx(5);
        rx_pulse(5, 5, 1'b0, "R10");

        // Disabled paths stay idle (R11).
        @(negedge clk); #1;
        tx_en = 1'b0;
        rx_en = 1'b0;
        tx_cfg = 8'd0;
        rx_cfg = 8'd0;
        send_frame(8'h00, 0, 1'b1, "R11");
        rx_pulse(4, 0, 1'b1, "R11");

        finish_run();
    end

endmodule